// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management bus. It can issue frames in either the short (Clause 22) format or the extended (Clause 45) format. Software first fills the extended-address and write-data registers as needed. It then writes a command word that holds the frame kind, the opcode, the port address and the device or register number, with the start bit set. The block shifts the whole frame out on MDC/MDIO, releases the data line for read turnarounds, and captures the returned 16-bit value. The start bit reads back as 1 for as long as the frame runs, so it also serves as the busy flag.

An extended-format register read takes two frames. The first is an address frame (opcode 0) that carries the extended-address register. After busy drops, a read frame (opcode 3) follows, sent to the same port and device. If the PHY does not pull MDIO low during the second turnaround bit of a read, the status flag is set, and the read-data register must then be treated as invalid.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads 0, MDC is low and MDIO is released (mdio_oe = 0). The byte offsets are: command 0x00, extended address 0x04, write data 0x08, read data 0x0C, status 0x10.
- R2: The command word places the device/register number in bits [4:0], the port in [9:5], the opcode in [11:10], the frame kind in [13:12] (00 = Clause 45, 01 = Clause 22) and start in bit 14. Every frame sends, MSB first: 32 ones, the two frame-kind bits, the two opcode bits, 5 port bits, 5 device/register bits, 2 turnaround bits and 16 data bits.
- R3: A command write with bit 14 set starts a frame. Command bit 14 reads 1 until the frame ends and 0 afterwards. A frame is exactly 64 MDC periods long, it ends on a falling MDC edge, and MDC stays low while idle.
- R4: A command write made while a frame runs is ignored. The running frame is unchanged, no second frame follows, and the command readback keeps the accepted fields.
- R5: A Clause 45 frame with opcode 0 drives turnaround 10 and sends the extended-address register as its data.
- R6: Write frames (Clause 22 opcode 1, Clause 45 opcode 1) drive turnaround 10 and send the write-data register.
- R7: Read frames (Clause 22 opcode 2, Clause 45 opcodes 2 and 3) release MDIO from the first turnaround bit to the end of the frame. They load the 16 sampled data bits into the read-data register, and the post-increment read (Clause 45 opcode 2) does this exactly as the plain read does.
- R8: Status bit 0 is set when MDIO is sampled high in the second turnaround bit of a read and cleared by a read that sees it low. It changes only when a read frame completes.
- R9: The MDC period is 2*DIV_HALF system clocks. MDIO output changes only on the falling MDC edge, and input is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data (combinational on bus_addr) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A table of frames covers every frame kind and opcode pairing. It includes a short-format write and read, an extended address frame, an extended write, a plain read, a post-increment read, a failing read, and all-zero and all-one field values. The address frame and the write frames must send different registers, so a wrong data source shows up in the captured frame. The failing read is followed by a write and then by a good read, which separates "status changes only on read completion" from "status cleared by any frame". A command written in mid-frame checks that the running frame and its readback are left alone.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        FK_EXT   = 2'b00,
        FK_SHORT = 2'b01,
        FK_RSV2  = 2'b10,
        FK_RSV3  = 2'b11
    } frame_kind_e;

    typedef struct packed {
        frame_kind_e kind;   // [13:12]
        logic [1:0]  op;     // [11:10]
        logic [4:0]  port;   // [9:5]
        logic [4:0]  dev;    // [4:0]
    } mdio_cmd_t;

    localparam logic [4:0] OFS_CMD  = 5'h00;
    localparam logic [4:0] OFS_ADDR = 5'h04;
    localparam logic [4:0] OFS_WDAT = 5'h08;
    localparam logic [4:0] OFS_RDAT = 5'h0C;
    localparam logic [4:0] OFS_STAT = 5'h10;
    localparam int         GO_BIT   = 14;

    function automatic logic cmd_is_read(mdio_cmd_t c);
        return (c.op == 2'd2) || (c.kind == FK_EXT && c.op == 2'd3);
    endfunction

    function automatic logic cmd_sends_addr(mdio_cmd_t c);
        return (c.kind == FK_EXT) && (c.op == 2'd0);
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_HALF = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

    logic [CW-1:0] cnt;
    logic          term;

    assign term      = run && (cnt == CW'(DIV_HALF - 1));
    assign rise_tick = term && !mdc;
    assign fall_tick = term && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (term) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic [DATA_W-1:0] addr_val,
    input  logic [DATA_W-1:0] wdata_val,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done_read,
    output logic [DATA_W-1:0] rd_val,
    output logic              rd_fail
);
    localparam int FRAME_LEN = PRE_LEN + 16 + DATA_W;
    localparam int IW        = $clog2(FRAME_LEN + 1);
    localparam int TA_FIRST  = PRE_LEN + 14;
    localparam int TA_SECOND = TA_FIRST + 1;
    localparam int LAST      = FRAME_LEN - 1;

    logic [FRAME_LEN-1:0] sreg;
    logic [IW-1:0]        idx;
    logic                 rd_mode;
    logic                 ta_bad;
    logic                 done;
    logic [DATA_W-1:0]    cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sreg    <= '1;
            idx     <= '0;
            rd_mode <= 1'b0;
            ta_bad  <= 1'b0;
            done    <= 1'b0;
            cap     <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy    <= 1'b1;
                idx     <= '0;
                rd_mode <= cmd_is_read(cmd);
                ta_bad  <= 1'b0;
                sreg    <= {{PRE_LEN{1'b1}}, cmd.kind, cmd.op, cmd.port, cmd.dev,
                            2'b10, cmd_sends_addr(cmd) ? addr_val : wdata_val};
            end else if (busy) begin
                if (rise_tick) begin
                    if (idx == IW'(TA_SECOND))
                        ta_bad <= mdio_i;
                    if (idx > IW'(TA_SECOND))
                        cap <= {cap[DATA_W-2:0], mdio_i};
                end
                if (fall_tick) begin
                    if (idx == IW'(LAST)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx  <= idx + 1'b1;
                        sreg <= sreg << 1;
                    end
                end
            end
        end
    end

    assign mdio_o    = busy ? sreg[FRAME_LEN-1] : 1'b1;
    assign mdio_oe   = busy && !(rd_mode && idx >= IW'(TA_FIRST));
    assign done_read = done && rd_mode;
    assign rd_val    = cap;
    assign rd_fail   = ta_bad;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              done_read,
    input  logic [DATA_W-1:0] rd_val,
    input  logic              rd_fail,
    output logic              start,
    output mdio_cmd_t         cmd,
    output logic [DATA_W-1:0] addr_val,
    output logic [DATA_W-1:0] wdata_val
);
    mdio_cmd_t         cmd_q;
    logic [DATA_W-1:0] addr_q, wdata_q, rdat_q;
    logic              fail_q;

    assign cmd   = mdio_cmd_t'(bus_wdata[13:0]);
    assign start = bus_wr && (bus_addr == OFS_CMD) && bus_wdata[GO_BIT] && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdat_q  <= '0;
            fail_q  <= 1'b0;
        end else begin
            if (start)
                cmd_q <= cmd;
            if (bus_wr && bus_addr == OFS_ADDR)
                addr_q <= bus_wdata;
            if (bus_wr && bus_addr == OFS_WDAT)
                wdata_q <= bus_wdata;
            if (done_read) begin
                rdat_q <= rd_val;
                fail_q <= rd_fail;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CMD:  bus_rdata = DATA_W'({busy, cmd_q});
            OFS_ADDR: bus_rdata = addr_q;
            OFS_WDAT: bus_rdata = wdata_q;
            OFS_RDAT: bus_rdata = rdat_q;
            OFS_STAT: bus_rdata = DATA_W'(fail_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign addr_val  = addr_q;
    assign wdata_val = wdata_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 50,
    parameter int PRE_LEN  = 32,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic              busy, start, done_read, rd_fail;
    logic              rise_tick, fall_tick;
    mdio_cmd_t         cmd;
    logic [DATA_W-1:0] addr_val, wdata_val, rd_val;

    mdio_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
        .done_read(done_read), .rd_val(rd_val), .rd_fail(rd_fail),
        .start(start), .cmd(cmd), .addr_val(addr_val), .wdata_val(wdata_val)
    );

    mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
        .clk(clk), .rst(rst), .run(busy), .mdc(mdc),
        .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_shifter #(.DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_shift (
        .clk(clk), .rst(rst), .start(start), .cmd(cmd),
        .addr_val(addr_val), .wdata_val(wdata_val),
        .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
        .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .done_read(done_read), .rd_val(rd_val), .rd_fail(rd_fail)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic clk,
    input logic rst,
    input logic cmd_go,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic busy
);
    // R3: idle means MDC low and MDIO released
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    // R3: a frame always ends after MDC was high, i.e. on a falling edge
    assert_end_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(mdc));

    // R4: a frame only begins from a start write on the previous cycle
    assert_start_from_write_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_go));

    // R9: MDIO drive is stable across the rising MDC edge
    assert_stable_at_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst(rst),
    .cmd_go(bus_wr && bus_addr == 5'h00 && bus_wdata[14]),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int DIVH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    mdio_master #(.DIV_HALF(DIVH)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    bit finished = 0;

    // PHY responder state
    logic [63:0] cap = '0;
    int          k = 0;
    int          rises = 0;
    logic        cur_rd = 1'b0;
    logic        oe_bad = 1'b0;
    logic [15:0] phy_data = '0;
    logic        phy_fail = 1'b0;
    realtime     last_rise = 0, mdc_per = 0;

    always @(posedge mdc) begin
        cap[63-k] <= mdio_oe ? mdio_o : 1'b1;
        if (cur_rd && k >= 46 && mdio_oe) oe_bad <= 1'b1;
        k <= (k == 63) ? 0 : k + 1;
        rises <= rises + 1;
        mdc_per <= $realtime - last_rise;
        last_rise <= $realtime;
    end

    always @(negedge mdc) begin
        if (cur_rd && k == 47)                mdio_i <= phy_fail;
        else if (cur_rd && k >= 48 && k <= 63) mdio_i <= phy_data[63-k];
        else                                   mdio_i <= 1'b1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] d;
        for (int i = 0; i < 3000; i++) begin
            rd(5'h00, d);
            if (!d[14]) break;
        end
    endtask

    // {pad, kind, op, port, dev, addr, wdata, phy, fail}
    localparam int NV = 9;
    localparam logic [63:0] VEC [NV] = '{
        {1'b0, 2'd1, 2'd1, 5'd3,  5'h11, 16'h0000, 16'hA5C3, 16'h0000, 1'b0},
        {1'b0, 2'd1, 2'd2, 5'h1F, 5'h02, 16'h0000, 16'h0000, 16'h1234, 1'b0},
        {1'b0, 2'd0, 2'd0, 5'd5,  5'd1,  16'hBEEF, 16'h0F0F, 16'h0000, 1'b0},
        {1'b0, 2'd0, 2'd1, 5'd5,  5'd1,  16'hBEEF, 16'h0F0F, 16'h0000, 1'b0},
        {1'b0, 2'd0, 2'd3, 5'd5,  5'd1,  16'h0000, 16'h0000, 16'hCAFE, 1'b0},
        {1'b0, 2'd0, 2'd2, 5'd9,  5'd7,  16'h0000, 16'h0000, 16'h8001, 1'b0},
        {1'b0, 2'd1, 2'd2, 5'd4,  5'd6,  16'h0000, 16'h0000, 16'hFFFF, 1'b1},
        {1'b0, 2'd1, 2'd1, 5'd0,  5'd0,  16'h1111, 16'hFFFF, 16'h0000, 1'b0},
        {1'b0, 2'd0, 2'd3, 5'd0,  5'h1F, 16'h0000, 16'h0000, 16'h0000, 1'b0}
    };

    initial begin
        logic [15:0] d;
        logic [15:0] exp_rd = '0;
        logic        exp_fail = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(5'h00, d); chk("R1 cmd", d, 0);
        rd(5'h04, d); chk("R1 addr", d, 0);
        rd(5'h08, d); chk("R1 wdata", d, 0);
        rd(5'h0C, d); chk("R1 rdata", d, 0);
        rd(5'h10, d); chk("R1 status", d, 0);
        chk("R1 mdc/oe", {mdc, mdio_oe}, 0);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  kind  = VEC[v][62:61];
            logic [1:0]  op    = VEC[v][60:59];
            logic [4:0]  port  = VEC[v][58:54];
            logic [4:0]  dev   = VEC[v][53:49];
            logic [15:0] aval  = VEC[v][48:33];
            logic [15:0] wval  = VEC[v][32:17];
            logic        isrd  = (op == 2'd2) || (kind == 2'd0 && op == 2'd3);
            logic [15:0] dval  = (kind == 2'd0 && op == 2'd0) ? aval : wval;
            logic [63:0] expf  = {32'hFFFF_FFFF, kind, op, port, dev, 2'b10, dval};
            int          r0;
            wr(5'h04, aval);
            wr(5'h08, wval);
            phy_data = VEC[v][16:1];
            phy_fail = VEC[v][0];
            cur_rd   = isrd;
            oe_bad   = 1'b0;
            r0       = rises;
            wr(5'h00, {1'b0, 1'b1, kind, op, port, dev});
            rd(5'h00, d); chk("R3 busy set", d[14], 1);
            wait_idle();
            chk("R3 64 mdc periods", rises - r0, 64);
            chk("R9 mdc period", longint'(mdc_per), longint'(2 * DIVH * 4));
            if (isrd) begin
                chk("R2/R7 read header", cap[63:18], expf[63:18]);
                chk("R7 released", oe_bad, 0);
                exp_rd   = VEC[v][16:1];
                exp_fail = VEC[v][0];
            end else if (kind == 2'd0 && op == 2'd0) begin
                chk("R2/R5 addr frame", cap, expf);
            end else begin
                chk("R2/R6 write frame", cap, expf);
            end
            rd(5'h0C, d); chk("R7 rdata", d, exp_rd);
            rd(5'h10, d); chk("R8 status", d, exp_fail);
            rd(5'h00, d); chk("R3 cmd readback", d, {2'b00, kind, op, port, dev});
        end

        // R4: command written mid-frame is ignored
        begin
            int r0;
            wr(5'h08, 16'h5A5A);
            cur_rd = 1'b0;
            r0 = rises;
            wr(5'h00, {2'b01, 2'd1, 2'd1, 5'd3, 5'd1});
            repeat (100) @(negedge clk);
            wr(5'h00, {2'b01, 2'd1, 2'd2, 5'h1A, 5'd2});
            wait_idle();
            chk("R4 frame intact", cap, {32'hFFFF_FFFF, 2'd1, 2'd1, 5'd3, 5'd1, 2'b10, 16'h5A5A});
            chk("R4 cmd readback", bus_rdata, {2'b00, 2'd1, 2'd1, 5'd3, 5'd1});
            repeat (40) @(negedge clk);
            chk("R4 no second frame", rises - r0, 64);
            chk("R3 idle mdc", {mdc, mdio_oe}, 0);
            rd(5'h10, d); chk("R8 status untouched by write", d, exp_fail);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule